// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines. It keeps three 8-bit registers: pending requests, requests in service, and a mask. It picks the pending, unmasked request with the best priority, provided no request of equal or better priority is still in service. When the host acknowledges, it returns a vector equal to a vector base plus the winning level. The winning request then moves from pending to in service.

Priority is circular. A 3-bit register names the level with the least priority, and the level just after it has the most. The host sends one command word at a time: a 3-bit operation code and a 3-bit level. A command can end service at a level, rotate the priority circle, or do both. A synchronous initialization strobe returns the block to its power-up arrangement, in which level 0 has the most priority and level 7 the least.

Top module: `irq_prio_core`

## Requirements
- R1: After reset or an `init_i` pulse, pending, in-service and mask registers are all zero, `lowest_o` is 7 and `cmd_last_o` is 3'b001. An `init_i` pulse ignores `req_i` in that same cycle.
- R2: With the power-up arrangement, a lower level number wins over a higher one. A pulse on `ack_i` with a winner present makes `vec_valid_o` high in the following cycle for one cycle, with `vec_o = vec_base_i + level`.
- R3: An acknowledge clears the winner's bit in `irr_o` and sets it in `isr_o`. At most one in-service bit becomes set per cycle.
- R4: A request whose mask bit is 1 never wins. If only masked requests are pending, `int_o` stays low.
- R5: A pending request is blocked while any in-service bit of equal or higher priority is set. A request of higher priority than every in-service bit still raises `int_o` and wins.
- R6: Code 3'b001 clears the highest-priority in-service bit and leaves `lowest_o` unchanged.
- R7: Code 3'b011 clears the in-service bit named by `cmd_level_i`.
- R8: Code 3'b101 clears the highest-priority in-service bit and makes that level the least-priority level. If no bit is in service, `lowest_o` is unchanged.
- R9: Code 3'b110 sets `lowest_o` to `cmd_level_i` and leaves `isr_o` unchanged.
- R10: Code 3'b111 clears the in-service bit named by `cmd_level_i` and sets `lowest_o` to that level.
- R11: Codes 3'b000 and 3'b100 change no state, and `cmd_last_o` keeps its value. Code 3'b010 changes nothing except that `cmd_last_o` records it. Every other code is recorded in `cmd_last_o`.
- R12: An acknowledge with no eligible request produces no `vec_valid_o` pulse and changes no register.
- R13: After a rotation, arbitration scans upward from the level just above `lowest_o`, wrapping from 7 to 0, and the vector follows that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous return to the power-up arrangement |
| vec_base_i | input | VEC_W | Base added to the level to form the vector |
| req_i | input | 8 | Request lines, each high cycle sets the pending bit |
| mask_wr_i | input | 1 | Load `mask_i` into the mask register |
| mask_i | input | 8 | New mask value, 1 blocks the level |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_code_i | input | 3 | Operation code |
| cmd_level_i | input | 3 | Level operand of the command |
| ack_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | An eligible request is waiting |
| vec_valid_o | output | 1 | `vec_o` holds a vector this cycle |
| vec_o | output | VEC_W | Returned vector |
| irr_o | output | 8 | Pending request register |
| isr_o | output | 8 | In-service register |
| lowest_o | output | 3 | Level that currently has the least priority |
| cmd_last_o | output | 3 | Last recorded operation code |

## Verification
A wrong priority base shows up directly as the wrong level in the vector returned for the next acknowledge, or as a change in `lowest_o` one cycle after the command. A stale or wrongly cleared in-service bit appears on `isr_o` one cycle after the command. It also shows up later: a request is wrongly blocked (`int_o` low when a winner is expected), or nested service is wrongly allowed. The checks therefore compare the returned vector, `int_o` and both registers after every step, against a circular scan done in the bench, so that a fault surfaces within one or two cycles of its cause.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_N = 8;
  localparam int LVL_W = $clog2(LVL_N);

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    OP_RSV_A    = 3'b000,
    OP_EOI_TOP  = 3'b001,
    OP_IDLE     = 3'b010,
    OP_EOI_AT   = 3'b011,
    OP_RSV_B    = 3'b100,
    OP_EOI_ROT  = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_EOI_LOW  = 3'b111
  } op_e;

  // rank 0 is the best priority: the level right after the lowest one
  function automatic lvl_t rank_to_level(lvl_t rank, lvl_t low);
    return lvl_t'(rank + low + lvl_t'(1));
  endfunction

  function automatic lvl_t level_to_rank(lvl_t lvl, lvl_t low);
    return lvl_t'(lvl - low - lvl_t'(1));
  endfunction
endpackage

// File: rtl/irq_rank_scan.sv
module irq_rank_scan
  import irq_prio_pkg::*;
(
  input  logic [LVL_N-1:0] bits_i,
  input  lvl_t             low_i,
  output logic             found_o,
  output lvl_t             lvl_o,
  output lvl_t             rank_o
);
  logic [LVL_N-1:0] by_rank;

  for (genvar r = 0; r < LVL_N; r++) begin : g_rot
    assign by_rank[r] = bits_i[rank_to_level(lvl_t'(r), low_i)];
  end

  always_comb begin
    found_o = 1'b0;
    rank_o  = '0;
    for (int r = LVL_N - 1; r >= 0; r--) begin
      if (by_rank[r]) begin
        found_o = 1'b1;
        rank_o  = lvl_t'(r);
      end
    end
  end

  assign lvl_o = rank_to_level(rank_o, low_i);
endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_prio_pkg::*;
(
  input  logic             valid_i,
  input  logic [2:0]       code_i,
  input  lvl_t             level_i,
  input  logic             top_found_i,
  input  lvl_t             top_lvl_i,
  output logic [LVL_N-1:0] clr_o,
  output logic             low_we_o,
  output lvl_t             low_o,
  output logic             record_o
);
  always_comb begin
    clr_o    = '0;
    low_we_o = 1'b0;
    low_o    = level_i;
    record_o = 1'b0;
    if (valid_i) begin
      case (op_e'(code_i))
        OP_EOI_TOP: begin
          record_o = 1'b1;
          if (top_found_i) clr_o[top_lvl_i] = 1'b1;
        end
        OP_IDLE: record_o = 1'b1;
        OP_EOI_AT: begin
          record_o       = 1'b1;
          clr_o[level_i] = 1'b1;
        end
        OP_EOI_ROT: begin
          record_o = 1'b1;
          low_o    = top_lvl_i;
          low_we_o = top_found_i;
          if (top_found_i) clr_o[top_lvl_i] = 1'b1;
        end
        OP_SET_LOW: begin
          record_o = 1'b1;
          low_we_o = 1'b1;
        end
        OP_EOI_LOW: begin
          record_o       = 1'b1;
          clr_o[level_i] = 1'b1;
          low_we_o       = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [VEC_W-1:0] vec_base_i,
  input  logic [7:0]       req_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_code_i,
  input  logic [2:0]       cmd_level_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [7:0]       irr_o,
  output logic [7:0]       isr_o,
  output logic [2:0]       lowest_o,
  output logic [2:0]       cmd_last_o
);
  localparam lvl_t       LOW_RST = lvl_t'(LVL_N - 1);
  localparam logic [2:0] CMD_RST = 3'b001;

  logic [LVL_N-1:0] irr_q, isr_q, imr_q;
  lvl_t             low_q;
  logic [2:0]       cmd_q;
  logic             vld_q;
  logic [VEC_W-1:0] vec_q;

  // events brought out for the checker
  logic             pend_found, top_found, win_ok, ack_take;
  lvl_t             pend_lvl, pend_rank, top_lvl, top_rank;
  logic [LVL_N-1:0] eoi_clr, ack_set, pend_bits;
  logic             low_we, rec_we;
  lvl_t             low_new;

  assign pend_bits = irr_q & ~imr_q;

  irq_rank_scan u_pend_scan (
    .bits_i (pend_bits),
    .low_i  (low_q),
    .found_o(pend_found),
    .lvl_o  (pend_lvl),
    .rank_o (pend_rank)
  );

  irq_rank_scan u_isr_scan (
    .bits_i (isr_q),
    .low_i  (low_q),
    .found_o(top_found),
    .lvl_o  (top_lvl),
    .rank_o (top_rank)
  );

  irq_cmd_decode u_dec (
    .valid_i    (cmd_valid_i),
    .code_i     (cmd_code_i),
    .level_i    (lvl_t'(cmd_level_i)),
    .top_found_i(top_found),
    .top_lvl_i  (top_lvl),
    .clr_o      (eoi_clr),
    .low_we_o   (low_we),
    .low_o      (low_new),
    .record_o   (rec_we)
  );

  assign win_ok   = pend_found && (!top_found || (pend_rank < top_rank));
  assign ack_take = ack_i && win_ok;

  always_comb begin
    ack_set = '0;
    if (ack_take) ack_set[pend_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
      low_q <= LOW_RST;
      cmd_q <= CMD_RST;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else if (init_i) begin
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
      low_q <= LOW_RST;
      cmd_q <= CMD_RST;
      vld_q <= 1'b0;
    end else begin
      irr_q <= (irr_q & ~ack_set) | req_i;
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
      if (mask_wr_i) imr_q <= mask_i;
      if (low_we)    low_q <= low_new;
      if (rec_we)    cmd_q <= cmd_code_i;
      vld_q <= ack_take;
      if (ack_take) vec_q <= vec_base_i + VEC_W'(pend_lvl);
    end
  end

  assign int_o       = win_ok;
  assign vec_valid_o = vld_q;
  assign vec_o       = vec_q;
  assign irr_o       = irr_q;
  assign isr_o       = isr_q;
  assign lowest_o    = low_q;
  assign cmd_last_o  = cmd_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_i,
  input logic [VEC_W-1:0] vec_base_i,
  input logic             mask_wr_i,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_code_i,
  input logic [2:0]       cmd_level_i,
  input logic             ack_i,
  input logic             ack_take,
  input logic             int_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [7:0]       irr_o,
  input logic [7:0]       isr_o,
  input logic [2:0]       lowest_o,
  input logic [2:0]       cmd_last_o
);
  logic [VEC_W-1:0] base_q;
  logic [2:0]       got_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= vec_base_i;
  end
  assign got_lvl = 3'(vec_o - base_q);

  // R1
  init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (isr_o == 8'h00) && (irr_o == 8'h00) && (lowest_o == 3'd7) && (cmd_last_o == 3'b001));

  // R2
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_i));

  // R3
  vec_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !$past(cmd_valid_i)) |-> isr_o[got_lvl]);

  // R3
  one_new_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_o & ~$past(isr_o)));

  // R4
  int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (irr_o != 8'h00));

  // R9
  set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_code_i == 3'b110 && !init_i) |=> (lowest_o == $past(cmd_level_i)));

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_code_i[1:0] == 2'b00 && !ack_i && !init_i && !mask_wr_i)
      |=> ($stable(isr_o) && $stable(lowest_o) && $stable(cmd_last_o)));

  // R12
  no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !ack_take && !init_i) |=> !vec_valid_o);
endmodule

bind irq_prio_core irq_prio_core_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_i     (init_i),
  .vec_base_i (vec_base_i),
  .mask_wr_i  (mask_wr_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_code_i (cmd_code_i),
  .cmd_level_i(cmd_level_i),
  .ack_i      (ack_i),
  .ack_take   (ack_take),
  .int_o      (int_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .irr_o      (irr_o),
  .isr_o      (isr_o),
  .lowest_o   (lowest_o),
  .cmd_last_o (cmd_last_o)
);

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
  localparam logic [7:0] BASE = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_i = 1'b0;
  logic [7:0] vec_base_i = BASE;
  logic [7:0] req_i = '0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_i = '0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_code_i = '0;
  logic [2:0] cmd_level_i = '0;
  logic       ack_i = 1'b0;
  logic       int_o, vec_valid_o;
  logic [7:0] vec_o, irr_o, isr_o;
  logic [2:0] lowest_o, cmd_last_o;

  always #10 clk = ~clk;

  irq_prio_core uut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .vec_base_i(vec_base_i),
    .req_i(req_i), .mask_wr_i(mask_wr_i), .mask_i(mask_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cmd_level_i(cmd_level_i),
    .ack_i(ack_i), .int_o(int_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o),
    .irr_o(irr_o), .isr_o(isr_o), .lowest_o(lowest_o), .cmd_last_o(cmd_last_o)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] m_irr = '0, m_isr = '0, m_imr = '0;
  logic [2:0] m_low = 3'd7, m_cmd = 3'b001;

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // circular scan from the level above the lowest one
  function automatic int expect_winner();
    for (int k = 1; k <= 8; k++) begin
      int l = (int'(m_low) + k) % 8;
      if (m_isr[l]) return -1;
      if (m_irr[l] && !m_imr[l]) return l;
    end
    return -1;
  endfunction

  function automatic int expect_top_isr();
    for (int k = 1; k <= 8; k++) begin
      int l = (int'(m_low) + k) % 8;
      if (m_isr[l]) return l;
    end
    return -1;
  endfunction

  task automatic check_state(string req);
    check(req, "irr", irr_o, m_irr);
    check(req, "isr", isr_o, m_isr);
    check(req, "lowest", lowest_o, m_low);
    check(req, "cmd_last", cmd_last_o, m_cmd);
    check(req, "int", int_o, expect_winner() >= 0);
  endtask

  // monitor: pops the expected vector whenever the design presents one
  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected vector actual=%0h expected=none", vec_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (vec_o !== e) begin
          n_bad++;
          $display("FAIL R2/R13 vector actual=%0h expected=%0h", vec_o, e);
        end
      end
    end
  end

  task automatic raise(logic [7:0] bits);
    req_i = bits;
    m_irr = m_irr | bits;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic load_mask(logic [7:0] m);
    mask_wr_i = 1'b1;
    mask_i = m;
    m_imr = m;
    @(negedge clk);
    mask_wr_i = 1'b0;
  endtask

  task automatic acknowledge();
    int w;
    w = expect_winner();
    if (w >= 0) begin
      exp_q.push_back(BASE + 8'(w));
      m_irr[w] = 1'b0;
      m_isr[w] = 1'b1;
    end
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic command(logic [2:0] code, logic [2:0] lvl);
    int t;
    t = expect_top_isr();
    case (code)
      3'b001: begin if (t >= 0) m_isr[t] = 1'b0; m_cmd = code; end
      3'b010: m_cmd = code;
      3'b011: begin m_isr[lvl] = 1'b0; m_cmd = code; end
      3'b101: begin if (t >= 0) begin m_isr[t] = 1'b0; m_low = 3'(t); end m_cmd = code; end
      3'b110: begin m_low = lvl; m_cmd = code; end
      3'b111: begin m_isr[lvl] = 1'b0; m_low = lvl; m_cmd = code; end
      default: ;
    endcase
    cmd_valid_i = 1'b1;
    cmd_code_i = code;
    cmd_level_i = lvl;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing vectors actual=%0d expected=0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL ALL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");                           // reset state
    check("R1", "vec_valid", vec_valid_o, 1'b0);

    raise(8'h28);                                // levels 3 and 5
    check_state("R2");
    acknowledge();                               // R2 R3: level 3 wins
    check("R2", "vec_valid", vec_valid_o, 1'b1);
    check_state("R3");
    acknowledge();                               // R5: level 5 blocked by 3
    check("R5", "vec_valid", vec_valid_o, 1'b0);
    check_state("R5");

    raise(8'h01);                                // R5: level 0 nests over 3
    check("R5", "int", int_o, 1'b1);
    acknowledge();
    check_state("R5");

    command(3'b001, 3'd6);                       // R6: clears level 0
    check_state("R6");
    command(3'b011, 3'd3);                       // R7
    check_state("R7");
    acknowledge();                               // level 5
    check_state("R3");
    command(3'b101, 3'd0);                       // R8: level 5 becomes lowest
    check_state("R8");
    command(3'b101, 3'd0);                       // R8: nothing in service
    check_state("R8");

    raise(8'hFF);
    load_mask(8'h40);                            // R4: level 6 masked
    acknowledge();                               // R13: 6 skipped, 7 wins
    check_state("R13");

    command(3'b000, 3'd1);                       // R11
    check_state("R11");
    command(3'b100, 3'd2);                       // R11
    check_state("R11");
    command(3'b010, 3'd4);                       // R11
    check_state("R11");

    command(3'b110, 3'd2);                       // R9
    check_state("R9");
    acknowledge();                               // R13: level 3 wins
    check_state("R13");
    command(3'b111, 3'd3);                       // R10
    check_state("R10");
    acknowledge();                               // level 4
    check_state("R13");

    command(3'b011, 3'd4);
    command(3'b011, 3'd7);
    load_mask(8'hFF);
    check("R4", "int", int_o, 1'b0);
    acknowledge();                               // R12: nothing eligible
    check("R12", "vec_valid", vec_valid_o, 1'b0);
    check_state("R12");

    init_i = 1'b1;                               // R1 via init
    req_i = 8'h10;
    @(negedge clk);
    init_i = 1'b0;
    req_i = '0;
    m_irr = '0; m_isr = '0; m_imr = '0; m_low = 3'd7; m_cmd = 3'b001;
    check_state("R1");

    raise(8'hFF);                                // R2: full fixed order
    for (int i = 0; i < 8; i++) begin
      acknowledge();
      check("R2", "isr", isr_o, m_isr);
      command(3'b001, 3'd0);
    end
    check_state("R2");
    @(negedge clk);
    finish_run();
  end
endmodule